// File: doc/BRIEF.md
# Backlight PWM Generator with Fractional Duty Dithering

This block drives a display backlight with a pulse-width-modulated signal. Software sets the period length through a bit-count field and a period value. It sets the duty cycle as a 16-bit left-aligned number: the upper bits, as many as the bit count, give the whole number of high ticks in each period. The remaining lower bits are a fraction. In fractional mode an accumulator spreads that fraction over successive periods, so the average high time resolves below one tick.

Duty and fractional-mode updates are double-buffered. A write to the control register lands in a shadow copy and marks an update as pending. When no lock holds it, the shadow is copied to the active copy at the end of a period, or at once while the output is disabled. A group lock bit and a global lock input let software stage a new duty value and release it atomically. A per-group override bit makes the global lock irrelevant for this group. The period counter advances only on cycles where the reference tick enable is high.

The generator is a three-state machine: OFF (output disabled), HIGH (inside the high part of a period) and LOW (rest of the period). Transitions are:
- start: OFF to HIGH or LOW, when enabled.
- threshold reached: HIGH to LOW.
- period restart: LOW to HIGH, when the next threshold is non-zero.
- disable: any state to OFF.

Top module: `bklt_pwm`

## Requirements
- R1: After reset the control register holds 0xC000FA00 (enable, fractional mode, duty 0xFA00) and the period register 0x000C0FA0 (bit count 12, period 0x0FA0). The output is therefore high continuously once running, and pending reads 0.
- R2: The period register (address 1) holds the period value in bits 15:0 and the bit count in bits 20:16. A bit count of 0, or above 16, means 16. The period value is masked to its low bit-count bits, and a masked value of 0 gives a period of 2^bitcount−1 ticks.
- R3: The control register (address 0) holds the duty value in bits 15:0. Its top bit-count bits are the integer part, and the output is high for that many ticks at the start of each period. An integer part at or above the period length keeps the output high all the time, and 0 keeps it low.
- R4: With control bit 30 (fractional mode) at 0, the low 16−bitcount duty bits have no effect on the output.
- R5: With control bit 30 at 1, each period end adds the fraction to an accumulator. An overflow lengthens the next period's high time by one tick, so over a repeating window the high count equals integer part plus fraction/2^(16−bitcount) per period.
- R6: With control bit 31 (enable) at 0, the output is low and the period counter and accumulator are cleared. After re-enabling, a fresh period starts with its high part on the second clock after the write.
- R7: The period counter advances only on cycles where the reference tick enable input is 1.
- R8: A control write updates only the shadow duty and mode. The active copy takes the shadow only at a period end, or while disabled, so a running period is never cut short.
- R9: Lock register (address 2) bit 0 set blocks the shadow-to-active copy. The pending output is 1 from any control write until the copy has happened, and clears after the lock is released and the next period ends.
- R10: The global lock input blocks the copy in the same way, unless lock register bit 1 (override) is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 period, 2 lock |
| reg_wdata | input | 32 | Register write data |
| glb_lock | input | 1 | Global update lock from the surrounding chip |
| tick_en | input | 1 | Reference tick enable for the period counter |
| pwm_out | output | 1 | Backlight PWM output |
| upd_pending | output | 1 | Duty update waiting to reach the active copy |

## Verification
A corrupted period counter or a threshold loaded from the wrong copy shows at the output as a wrong number of high ticks in each period. Counting high samples over a window that spans a whole number of output periods exposes it within one or two periods. A wrong fractional accumulator shifts that count by whole ticks over the dither cycle of at most a few periods. A broken shadow/active hand-off or a broken lock shows as the pending output stuck or clearing early, and as the high count changing while a lock is held. A restart fault after disable shows in the first four samples after enabling.

// File: rtl/bklt_pkg.sv
package bklt_pkg;
    localparam int DUTY_W  = 16;
    localparam int BCNT_W  = 5;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 32;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_PRD  = 2'd1;
    localparam logic [ADDR_W-1:0] A_LOCK = 2'd2;

    localparam int CTRL_EN_BIT   = 31;
    localparam int CTRL_FRAC_BIT = 30;
    localparam int PRD_BC_LSB    = 16;
    localparam int LOCK_GRP_BIT  = 0;
    localparam int LOCK_IGN_BIT  = 1;

    localparam logic [DATA_W-1:0] CTRL_RST = 32'hC000_FA00;
    localparam logic [DATA_W-1:0] PRD_RST  = 32'h000C_0FA0;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } pwm_st_e;
endpackage

// File: rtl/bklt_regs.sv
module bklt_regs
    import bklt_pkg::*;
#(
    parameter int DW  = DUTY_W,
    parameter int BCW = BCNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              glb_lock_i,
    input  logic              prd_end_i,
    output logic              en_o,
    output logic [DW-1:0]     nxt_duty_o,
    output logic              nxt_frac_o,
    output logic [DW-1:0]     plen_o,
    output logic [BCW-1:0]    bc_o,
    output logic              pend_o
);
    localparam int PW = DW + 1;

    logic           en_q;
    logic [DW-1:0]  sh_duty_q, ac_duty_q;
    logic           sh_frac_q, ac_frac_q;
    logic [DW-1:0]  prd_val_q;
    logic [BCW-1:0] prd_bc_q;
    logic           lk_grp_q, lk_ign_q;
    logic           dirty_q;

    logic           wr_ctrl, wr_prd, wr_lock;
    logic           eff_lock, xfer;
    logic [BCW-1:0] bc_eff;
    logic [PW-1:0]  full_mask;
    logic [DW-1:0]  prd_masked;

    assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
    assign wr_prd  = wr_en_i && (wr_addr_i == A_PRD);
    assign wr_lock = wr_en_i && (wr_addr_i == A_LOCK);

    // group lock, or global lock when not overridden
    assign eff_lock = lk_grp_q || (glb_lock_i && !lk_ign_q);
    assign xfer     = dirty_q && !eff_lock && (prd_end_i || !en_q);

    // bit count of 0 or out of range selects the full width
    always_comb begin
        if ((prd_bc_q == '0) || (prd_bc_q > BCW'(DW)))
            bc_eff = BCW'(DW);
        else
            bc_eff = prd_bc_q;
        full_mask  = (PW'(1) << bc_eff) - PW'(1);
        prd_masked = prd_val_q & full_mask[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= CTRL_RST[CTRL_EN_BIT];
            sh_frac_q <= CTRL_RST[CTRL_FRAC_BIT];
            ac_frac_q <= CTRL_RST[CTRL_FRAC_BIT];
            sh_duty_q <= CTRL_RST[DW-1:0];
            ac_duty_q <= CTRL_RST[DW-1:0];
            prd_val_q <= PRD_RST[DW-1:0];
            prd_bc_q  <= PRD_RST[PRD_BC_LSB +: BCW];
            lk_grp_q  <= 1'b0;
            lk_ign_q  <= 1'b0;
            dirty_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q      <= wr_data_i[CTRL_EN_BIT];
                sh_frac_q <= wr_data_i[CTRL_FRAC_BIT];
                sh_duty_q <= wr_data_i[DW-1:0];
            end
            if (wr_prd) begin
                prd_val_q <= wr_data_i[DW-1:0];
                prd_bc_q  <= wr_data_i[PRD_BC_LSB +: BCW];
            end
            if (wr_lock) begin
                lk_grp_q <= wr_data_i[LOCK_GRP_BIT];
                lk_ign_q <= wr_data_i[LOCK_IGN_BIT];
            end
            if (xfer) begin
                ac_duty_q <= sh_duty_q;
                ac_frac_q <= sh_frac_q;
            end
            if (wr_ctrl)
                dirty_q <= 1'b1;
            else if (xfer)
                dirty_q <= 1'b0;
        end
    end

    assign en_o       = en_q;
    assign nxt_duty_o = xfer ? sh_duty_q : ac_duty_q;
    assign nxt_frac_o = xfer ? sh_frac_q : ac_frac_q;
    assign plen_o     = (prd_masked == '0) ? full_mask[DW-1:0] : prd_masked;
    assign bc_o       = bc_eff;
    assign pend_o     = dirty_q;

    // R8: active copy moves only at a period end or while disabled
    p_act_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ac_duty_q) |-> $past(prd_end_i || !en_q));

    // R9: group lock freezes the active copy
    p_grp_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_grp_q |=> $stable(ac_duty_q));

    // R9: a control write always leaves an update pending
    p_pend_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> pend_o);

    // R10: global lock without override freezes the active copy
    p_glb_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_lock_i && !lk_ign_q) |=> $stable(ac_duty_q));
endmodule

// File: rtl/bklt_gen.sv
module bklt_gen
    import bklt_pkg::*;
#(
    parameter int DW  = DUTY_W,
    parameter int BCW = BCNT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_en_i,
    input  logic           en_i,
    input  logic [DW-1:0]  nxt_duty_i,
    input  logic           nxt_frac_i,
    input  logic [DW-1:0]  plen_i,
    input  logic [BCW-1:0] bc_i,
    output logic           prd_end_o,
    output logic           pwm_o
);
    localparam int PW = DW + 1;

    pwm_st_e        st_q, st_n;
    logic [DW-1:0]  cnt_q, cnt_n;
    logic [DW-1:0]  acc_q, acc_n;
    logic [PW-1:0]  thr_q, thr_n;

    logic [BCW-1:0] frac_sh;
    logic [DW-1:0]  ipart;
    logic [DW-1:0]  ftop;
    logic [PW-1:0]  sum;
    logic           cmp_hi;

    assign frac_sh = BCW'(DW) - bc_i;
    assign ipart   = nxt_duty_i >> frac_sh;
    // fraction moved to the top of the word so the carry is width independent
    assign ftop    = nxt_frac_i ? (nxt_duty_i << bc_i) : '0;
    assign sum     = {1'b0, acc_q} + {1'b0, ftop};

    assign prd_end_o = en_i && (st_q != ST_OFF) && tick_en_i
                       && (cnt_q >= (plen_i - 1'b1));

    always_comb begin
        cnt_n = cnt_q;
        acc_n = acc_q;
        thr_n = thr_q;
        if (!en_i || (st_q == ST_OFF)) begin
            cnt_n = '0;
            acc_n = '0;
            thr_n = {1'b0, ipart};
        end else if (prd_end_o) begin
            cnt_n = '0;
            acc_n = sum[DW-1:0];
            thr_n = {1'b0, ipart} + PW'(sum[DW]);
        end else if (tick_en_i) begin
            cnt_n = cnt_q + 1'b1;
        end
    end

    assign cmp_hi = ({1'b0, cnt_n} < thr_n);

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_OFF:  if (en_i)        st_n = cmp_hi ? ST_HIGH : ST_LOW;
            ST_HIGH: if (!en_i)       st_n = ST_OFF;
                     else if (!cmp_hi) st_n = ST_LOW;
            ST_LOW:  if (!en_i)       st_n = ST_OFF;
                     else if (cmp_hi)  st_n = ST_HIGH;
            default:                  st_n = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            cnt_q <= '0;
            acc_q <= '0;
            thr_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            acc_q <= acc_n;
            thr_q <= thr_n;
        end
    end

    always_comb begin
        pwm_o = (st_q == ST_HIGH);
    end

    // R6: disabled means low output on the next cycle
    p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pwm_o);

    // R7: no tick, no counter movement while running
    p_tick_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_en_i && (st_q != ST_OFF)) |=> $stable(cnt_q));
endmodule

// File: rtl/bklt_pwm.sv
module bklt_pwm
    import bklt_pkg::*;
#(
    parameter int DW  = DUTY_W,
    parameter int BCW = BCNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              glb_lock,
    input  logic              tick_en,
    output logic              pwm_out,
    output logic              upd_pending
);
    logic           en;
    logic [DW-1:0]  nxt_duty;
    logic           nxt_frac;
    logic [DW-1:0]  plen;
    logic [BCW-1:0] bc;
    logic           prd_end;

    bklt_regs #(.DW(DW), .BCW(BCW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (reg_we),
        .wr_addr_i  (reg_addr),
        .wr_data_i  (reg_wdata),
        .glb_lock_i (glb_lock),
        .prd_end_i  (prd_end),
        .en_o       (en),
        .nxt_duty_o (nxt_duty),
        .nxt_frac_o (nxt_frac),
        .plen_o     (plen),
        .bc_o       (bc),
        .pend_o     (upd_pending)
    );

    bklt_gen #(.DW(DW), .BCW(BCW)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en_i  (tick_en),
        .en_i       (en),
        .nxt_duty_i (nxt_duty),
        .nxt_frac_i (nxt_frac),
        .plen_i     (plen),
        .bc_i       (bc),
        .prd_end_o  (prd_end),
        .pwm_o      (pwm_out)
    );
endmodule

// File: tb/sim_bklt_pwm.sv
`timescale 1ns/1ps
module sim_bklt_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        glb_lock = 1'b0;
    logic        tick_en;
    logic        half_mode = 1'b0;
    logic        pwm_out;
    logic        upd_pending;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bklt_pwm u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .glb_lock    (glb_lock),
        .tick_en     (tick_en),
        .pwm_out     (pwm_out),
        .upd_pending (upd_pending)
    );

    always @(negedge clk) begin
        if (!rst_n) tick_en <= 1'b1;
        else        tick_en <= half_mode ? ~tick_en : 1'b1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic count_hi(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c += int'(pwm_out);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // disable with the new duty, set period, then enable and settle
    task automatic cfg(input logic [31:0] prd, input logic [31:0] ctl);
        wr(2'd0, ctl & 32'h7FFF_FFFF);
        wr(2'd1, prd);
        idle(4);
        wr(2'd0, ctl);
        idle(40);
    endtask

    task automatic t_reset();
        int c;
        idle(3);
        chk("R1 pending after reset", int'(upd_pending), 0);
        count_hi(100, c);
        chk("R1 default duty keeps output high", c, 100);
    endtask

    task automatic t_basic();
        int c;
        cfg(32'h0004_001A, 32'h8000_3000);   // masked period 10
        count_hi(100, c);
        chk("R2 R3 three of ten ticks", c, 30);
    endtask

    task automatic t_nofrac();
        int c;
        cfg(32'h0004_000A, 32'h8000_3FFF);
        count_hi(100, c);
        chk("R4 fraction ignored", c, 30);
    endtask

    task automatic t_frac();
        int c;
        cfg(32'h0004_000A, 32'hC000_3800);
        count_hi(200, c);
        chk("R5 half fraction", c, 70);
        cfg(32'h0004_000A, 32'hC000_3400);
        count_hi(400, c);
        chk("R5 quarter fraction", c, 130);
    endtask

    task automatic t_limits();
        int c;
        cfg(32'h0004_000A, 32'h8000_C000);
        count_hi(100, c);
        chk("R3 duty above period stays high", c, 100);
        cfg(32'h0004_000A, 32'h8000_0000);
        count_hi(100, c);
        chk("R3 zero duty stays low", c, 0);
    endtask

    task automatic t_period_forms();
        int c;
        cfg(32'h0004_0000, 32'h8000_5000);   // period 0 -> 15 ticks
        count_hi(150, c);
        chk("R2 zero period is maximum", c, 50);
        cfg(32'h0000_0014, 32'h8000_0005);   // bit count 0 -> 16
        count_hi(200, c);
        chk("R2 bit count zero means sixteen", c, 50);
        cfg(32'h0014_0014, 32'h8000_0005);   // bit count 20 clamps
        count_hi(200, c);
        chk("R2 bit count above sixteen clamps", c, 50);
    endtask

    task automatic t_disable();
        int c;
        wr(2'd1, 32'h0004_000A);
        wr(2'd0, 32'h0000_3000);
        count_hi(50, c);
        chk("R6 disabled output low", c, 0);
        wr(2'd0, 32'h8000_3000);
        chk("R6 restart cycle 0", int'(pwm_out), 0);
        @(negedge clk); chk("R6 restart cycle 1", int'(pwm_out), 1);
        @(negedge clk); chk("R6 restart cycle 2", int'(pwm_out), 1);
        @(negedge clk); chk("R6 restart cycle 3", int'(pwm_out), 1);
        @(negedge clk); chk("R6 restart cycle 4", int'(pwm_out), 0);
    endtask

    task automatic t_tick();
        int c;
        half_mode = 1'b1;
        cfg(32'h0004_000A, 32'h8000_3000);
        count_hi(200, c);
        chk("R7 half-rate tick", c, 60);
        half_mode = 1'b0;
        idle(4);
    endtask

    task automatic t_lock();
        int c;
        cfg(32'h0004_000A, 32'h8000_3000);
        wr(2'd2, 32'h0000_0001);
        wr(2'd0, 32'h8000_6000);
        chk("R9 pending after locked write", int'(upd_pending), 1);
        count_hi(100, c);
        chk("R8 R9 active duty held under lock", c, 30);
        chk("R9 pending held under lock", int'(upd_pending), 1);
        wr(2'd2, 32'h0000_0000);
        idle(15);
        chk("R9 pending clears after unlock", int'(upd_pending), 0);
        count_hi(100, c);
        chk("R8 new duty after unlock", c, 60);
    endtask

    task automatic t_glb();
        int c;
        glb_lock = 1'b1;
        wr(2'd0, 32'h8000_2000);
        count_hi(100, c);
        chk("R10 global lock holds duty", c, 60);
        chk("R10 pending under global lock", int'(upd_pending), 1);
        wr(2'd2, 32'h0000_0002);
        idle(15);
        chk("R10 override releases", int'(upd_pending), 0);
        count_hi(100, c);
        chk("R10 duty after override", c, 20);
        glb_lock = 1'b0;
        wr(2'd2, 32'h0000_0000);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_nofrac();
        t_frac();
        t_limits();
        t_period_forms();
        t_disable();
        t_tick();
        t_lock();
        t_glb();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule